// File: doc/BRIEF.md
# Burst-Counting I2C Target Receiver

This block is the receive half of an I2C target that sits behind a small host register port. It watches the already-synchronized SCL and SDA lines for START and STOP conditions. It shifts in the address byte and compares it with a programmable 7-bit own address, and also with the general call address when that is enabled. When it matches, it acknowledges. It then collects a programmed number of data bytes, from 1 to 68, into an internal buffer. It acknowledges every byte on the ninth clock.

Each bus event that needs the host loads a distinct status code, raises an interrupt flag and pulls the active-low interrupt line. While the flag is pending in the data phase, the block holds SCL low so that the controller waits. The host reads the buffer through an index register and a data window, then clears the flag to let the bus run again. Within one sequence there is no interrupt per byte: the host is involved once per burst.

Top module: `i2c_burst_rx`

## Requirements
- R1: After reset, status (reg 3) reads F8h, control (reg 0) reads 00h, `irqN` is 1, and neither `sclLow` nor `sdaLow` is asserted.
- R2: With control bit 7 (enable) and bit 6 (acknowledge-enable) set, an address byte whose upper 7 bits equal reg 1 bits 7:1 and whose bit 0 is 0 (write) is acknowledged (SDA low on the 9th clock). After that 9th clock the flag (reg 0 bit 3) is set, `irqN` goes low and status becomes 60h. A different address, a read direction bit, or acknowledge-enable at 0 gives no acknowledge and no flag.
- R3: The address byte 00h is acknowledged with status D0h when reg 1 bit 0 is 1, whatever the acknowledge-enable bit is. It is ignored when reg 1 bit 0 is 0.
- R4: With control bit 7 at 0, the block never drives SDA or SCL and never sets the flag.
- R5: While the flag is set in the data phase, `sclLow` holds SCL low. Writing reg 0 with bit 3 at 0 clears the flag, releases SCL, returns `irqN` to 1 and loads status F8h. Writing bit 3 as 1 leaves the flag unchanged.
- R6: The flag is raised only after the programmed count (reg 2 bits 6:0) of data bytes. Status is then 80h after an own-address match or 90h after a general call. The bytes are readable at buffer indices 0 to count-1: write the index to reg 4, read the byte from reg 5. The next sequence stores from index 0 again.
- R7: A programmed count of 0 acts as 1, and any count above 68 acts as 68.
- R8: Every data byte except the final byte of a sequence is acknowledged. The final byte is acknowledged when acknowledge-enable is 1. When it is 0, the final byte is not acknowledged, status becomes 88h (own) or 98h (general call), and further bytes are ignored until a STOP or START.
- R9: A STOP or a repeated START while the block is addressed in the data phase sets the flag with status A0h. After a repeated START, the following address is matched again.
- R10: STOP or START while the block is not addressed changes neither the flag nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 3 | Host register select |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for the selected register (combinational) |
| sclIn | input | 1 | Synchronized SCL line level |
| sdaIn | input | 1 | Synchronized SDA line level |
| sclLow | output | 1 | Pull SCL low (clock stretch) |
| sdaLow | output | 1 | Pull SDA low (acknowledge) |
| irqN | output | 1 | Active-low interrupt, low while the flag is set |

## Verification
The bench targets the count boundaries. With a count of 0, a design that did not clamp would never raise the flag. With a count above 68, a design that did not clamp would overrun its buffer or raise the flag at the wrong byte. The bench also checks that the general call is still acknowledged with acknowledge-enable at 0. A design that tied the general call to that bit would stay silent. It checks the NACK on the final byte and that the following bytes are then ignored. A design that kept acknowledging would corrupt the buffer. Finally, it checks that a STOP or repeated START in mid-burst is reported with its own status, and that SCL stays low while the flag is pending. A design that got either wrong would let the controller run past data the host has not yet read.

// File: rtl/i2c_burst_rx_pkg.sv
package i2c_burst_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_DATA     = 3'd3,
    ST_DATA_ACK = 3'd4,
    ST_SKIP     = 3'd5
  } rx_state_e;

  localparam logic [7:0] STAT_IDLE          = 8'hF8;
  localparam logic [7:0] STAT_OWN_HIT       = 8'h60;
  localparam logic [7:0] STAT_GC_HIT        = 8'hD0;
  localparam logic [7:0] STAT_OWN_DONE      = 8'h80;
  localparam logic [7:0] STAT_OWN_DONE_NACK = 8'h88;
  localparam logic [7:0] STAT_GC_DONE       = 8'h90;
  localparam logic [7:0] STAT_GC_DONE_NACK  = 8'h98;
  localparam logic [7:0] STAT_STOP          = 8'hA0;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_OWN    = 3'd1;
  localparam logic [2:0] REG_COUNT  = 3'd2;
  localparam logic [2:0] REG_STATUS = 3'd3;
  localparam logic [2:0] REG_INDEX  = 3'd4;
  localparam logic [2:0] REG_DATA   = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic       shiftEn;
    logic       clrBits;
    logic       storeByte;
    logic       clrRx;
    logic       setFlag;
    logic [7:0] statCode;
  } rx_strobe_t;

endpackage

// File: rtl/i2c_burst_rx_events.sv
module i2c_burst_rx_events (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic sclQ;
  logic sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  // SDA moving while SCL stays high marks a bus condition
  assign startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;

endmodule

// File: rtl/i2c_burst_rx_ctrl.sv
module i2c_burst_rx_ctrl
  import i2c_burst_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       ifEn,
  input  logic       ackEn,
  input  logic [6:0] ownAddr,
  input  logic       gcEn,
  input  logic       flag,
  input  logic [7:0] rxByte,
  input  logic       byteFull,
  input  logic       lastByte,
  output rx_strobe_t strobe,
  output logic       sclLow,
  output logic       sdaLow
);

  rx_state_e stateQ, stateNext;
  logic sdaLowQ, sdaNext;
  logic gcModeQ, gcNext;
  logic lastQ, lastNext;
  logic nackQ, nackNext;
  logic addressed;
  logic ownHit;
  logic gcHit;
  logic isGcByte;
  logic [7:0] doneCode;

  assign addressed = (stateQ == ST_DATA) || (stateQ == ST_DATA_ACK);
  assign isGcByte  = (rxByte == 8'h00);
  assign ownHit    = (rxByte[7:1] == ownAddr) && !rxByte[0] && ackEn;
  assign gcHit     = isGcByte && gcEn;
  assign doneCode  = gcModeQ ? (nackQ ? STAT_GC_DONE_NACK : STAT_GC_DONE)
                             : (nackQ ? STAT_OWN_DONE_NACK : STAT_OWN_DONE);

  always_comb begin
    stateNext = stateQ;
    sdaNext   = sdaLowQ;
    gcNext    = gcModeQ;
    lastNext  = lastQ;
    nackNext  = nackQ;
    strobe    = '0;
    if (!ifEn) begin
      stateNext = ST_IDLE;
      sdaNext   = 1'b0;
    end else if (startSeen) begin
      if (addressed) begin
        strobe.setFlag  = 1'b1;
        strobe.statCode = STAT_STOP;
      end
      strobe.clrBits = 1'b1;
      stateNext      = ST_ADDR;
      sdaNext        = 1'b0;
    end else if (stopSeen) begin
      if (addressed) begin
        strobe.setFlag  = 1'b1;
        strobe.statCode = STAT_STOP;
      end
      stateNext = ST_IDLE;
      sdaNext   = 1'b0;
    end else begin
      unique case (stateQ)
        ST_ADDR: begin
          if (sclRise && !byteFull) begin
            strobe.shiftEn = 1'b1;
          end else if (sclFall && byteFull) begin
            gcNext = isGcByte;
            if (isGcByte ? gcHit : ownHit) begin
              stateNext = ST_ADDR_ACK;
              sdaNext   = 1'b1;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            sdaNext         = 1'b0;
            strobe.setFlag  = 1'b1;
            strobe.statCode = gcModeQ ? STAT_GC_HIT : STAT_OWN_HIT;
            strobe.clrBits  = 1'b1;
            strobe.clrRx    = 1'b1;
            stateNext       = ST_DATA;
          end
        end
        ST_DATA: begin
          if (sclRise && !byteFull) begin
            strobe.shiftEn = 1'b1;
          end else if (sclFall && byteFull) begin
            strobe.storeByte = 1'b1;
            lastNext  = lastByte;
            nackNext  = lastByte && !ackEn;
            sdaNext   = !(lastByte && !ackEn);
            stateNext = ST_DATA_ACK;
          end
        end
        ST_DATA_ACK: begin
          if (sclFall) begin
            sdaNext        = 1'b0;
            strobe.clrBits = 1'b1;
            if (lastQ) begin
              strobe.setFlag  = 1'b1;
              strobe.statCode = doneCode;
              strobe.clrRx    = 1'b1;
              stateNext       = nackQ ? ST_SKIP : ST_DATA;
            end else begin
              stateNext = ST_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      sdaLowQ <= 1'b0;
      gcModeQ <= 1'b0;
      lastQ   <= 1'b0;
      nackQ   <= 1'b0;
    end else begin
      stateQ  <= stateNext;
      sdaLowQ <= sdaNext;
      gcModeQ <= gcNext;
      lastQ   <= lastNext;
      nackQ   <= nackNext;
    end
  end

  assign sdaLow = sdaLowQ;
  assign sclLow = flag && (stateQ == ST_DATA);

  // SDA is only pulled during a ninth-clock acknowledge window
  assert_ack_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    sdaLowQ |-> (stateQ == ST_ADDR_ACK || stateQ == ST_DATA_ACK));

  // a disabled interface lets go of the bus on the next cycle
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ifEn |=> (!sdaLowQ && stateQ == ST_IDLE));

  // a stop-status interrupt only comes from the addressed phase
  assert_stop_from_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setFlag && strobe.statCode == STAT_STOP) |-> addressed);

endmodule

// File: rtl/i2c_burst_rx_datapath.sv
module i2c_burst_rx_datapath
  import i2c_burst_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 68,
  parameter int MAX_BURST = 68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  input  logic       sdaIn,
  input  rx_strobe_t strobe,
  output logic       ifEn,
  output logic       ackEn,
  output logic [6:0] ownAddr,
  output logic       gcEn,
  output logic       flag,
  output logic [7:0] rxByte,
  output logic       byteFull,
  output logic       lastByte
);

  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic             ifEnQ, ackEnQ, flagQ, gcEnQ;
  logic [6:0]       ownAddrQ;
  logic [6:0]       countQ;
  logic [7:0]       statusQ;
  logic [IDX_W-1:0] idxQ;
  logic [7:0]       shiftQ;
  logic [3:0]       bitCntQ;
  logic [CNT_W-1:0] rxCntQ;
  logic [CNT_W-1:0] effCount;
  logic [7:0]       bufMem [BUF_DEPTH];
  logic             ctrlWr;
  logic             clrReq;

  assign ctrlWr = hostWr && (hostAddr == REG_CTRL);
  assign clrReq = ctrlWr && !hostWrData[3];

  // clamp the programmed burst length into 1..MAX_BURST
  always_comb begin
    if (countQ == 7'd0)                   effCount = CNT_W'(1);
    else if (int'(countQ) > MAX_BURST)    effCount = CNT_W'(MAX_BURST);
    else                                  effCount = CNT_W'(countQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifEnQ    <= 1'b0;
      ackEnQ   <= 1'b0;
      gcEnQ    <= 1'b0;
      ownAddrQ <= '0;
      countQ   <= '0;
      idxQ     <= '0;
    end else if (hostWr) begin
      unique case (hostAddr)
        REG_CTRL: begin
          ifEnQ  <= hostWrData[7];
          ackEnQ <= hostWrData[6];
        end
        REG_OWN: begin
          ownAddrQ <= hostWrData[7:1];
          gcEnQ    <= hostWrData[0];
        end
        REG_COUNT: countQ <= hostWrData[6:0];
        REG_INDEX: idxQ   <= hostWrData[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  // interrupt flag and status: a new event wins over a host clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= 1'b0;
      statusQ <= STAT_IDLE;
    end else if (strobe.setFlag) begin
      flagQ   <= 1'b1;
      statusQ <= strobe.statCode;
    end else if (clrReq && flagQ) begin
      flagQ   <= 1'b0;
      statusQ <= STAT_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitCntQ <= '0;
    end else if (strobe.clrBits) begin
      bitCntQ <= '0;
    end else if (strobe.shiftEn) begin
      shiftQ  <= {shiftQ[6:0], sdaIn};
      bitCntQ <= bitCntQ + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxCntQ <= '0;
    else if (strobe.clrRx)     rxCntQ <= '0;
    else if (strobe.storeByte) rxCntQ <= rxCntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) bufMem[IDX_W'(rxCntQ)] <= shiftQ;
  end

  always_comb begin
    unique case (hostAddr)
      REG_CTRL:   hostRdData = {ifEnQ, ackEnQ, 2'b00, flagQ, 3'b000};
      REG_OWN:    hostRdData = {ownAddrQ, gcEnQ};
      REG_COUNT:  hostRdData = {1'b0, countQ};
      REG_STATUS: hostRdData = statusQ;
      REG_INDEX:  hostRdData = 8'(idxQ);
      REG_DATA:   hostRdData = (int'(idxQ) < BUF_DEPTH) ? bufMem[idxQ] : 8'h00;
      default:    hostRdData = 8'h00;
    endcase
  end

  assign ifEn     = ifEnQ;
  assign ackEn    = ackEnQ;
  assign ownAddr  = ownAddrQ;
  assign gcEn     = gcEnQ;
  assign flag     = flagQ;
  assign rxByte   = shiftQ;
  assign byteFull = (bitCntQ == 4'd8);
  assign lastByte = ((rxCntQ + CNT_W'(1)) == effCount);

  // only a host write with bit 3 low takes the flag down
  assert_flag_host_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(hostWr && hostAddr == REG_CTRL && !hostWrData[3]));

  assert_idle_after_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> (statusQ == STAT_IDLE));

  // byte counter never runs past the largest burst
  assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxCntQ) <= MAX_BURST);

  assert_bit_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitCntQ <= 4'd8);

endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx
  import i2c_burst_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 68,
  parameter int MAX_BURST = 68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       irqN
);

  logic       sclRise, sclFall, startSeen, stopSeen;
  logic       ifEn, ackEn, gcEn, flag, byteFull, lastByte;
  logic [6:0] ownAddr;
  logic [7:0] rxByte;
  rx_strobe_t strobe;

  i2c_burst_rx_events u_events (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  i2c_burst_rx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .ifEn      (ifEn),
    .ackEn     (ackEn),
    .ownAddr   (ownAddr),
    .gcEn      (gcEn),
    .flag      (flag),
    .rxByte    (rxByte),
    .byteFull  (byteFull),
    .lastByte  (lastByte),
    .strobe    (strobe),
    .sclLow    (sclLow),
    .sdaLow    (sdaLow)
  );

  i2c_burst_rx_datapath #(
    .BUF_DEPTH (BUF_DEPTH),
    .MAX_BURST (MAX_BURST)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .sdaIn      (sdaIn),
    .strobe     (strobe),
    .ifEn       (ifEn),
    .ackEn      (ackEn),
    .ownAddr    (ownAddr),
    .gcEn       (gcEn),
    .flag       (flag),
    .rxByte     (rxByte),
    .byteFull   (byteFull),
    .lastByte   (lastByte)
  );

  assign irqN = ~flag;

  // the bus is never stretched unless an interrupt is pending
  assert_stretch_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    sclLow |-> !irqN);

endmodule

// File: tb/i2c_burst_rx_tb.sv
module i2c_burst_rx_tb;

  localparam int Q = 6;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       sclLow, sdaLow, irqN;
  logic       sclLine, sdaLine;

  int nChecks = 0;
  int nFails = 0;

  assign sclLine = sclDrv & ~sclLow;
  assign sdaLine = sdaDrv & ~sdaLow;

  always #4 clk = ~clk;

  i2c_burst_rx u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .sclIn      (sclLine),
    .sdaIn      (sdaLine),
    .sclLow     (sclLow),
    .sdaLow     (sdaLow),
    .irqN       (irqN)
  );

  // own-reg value, ack-enable, count, address byte, expected ack, status after address, final status
  typedef struct packed {
    logic [7:0] own;
    logic       ackEn;
    logic [6:0] cnt;
    logic [7:0] addrByte;
    logic       expAck;
    logic [7:0] expAddrStat;
    logic [7:0] expFinal;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA4, 1'b1, 7'd3, 8'hA4, 1'b1, 8'h60, 8'h80},
    '{8'hA4, 1'b1, 7'd3, 8'hA5, 1'b0, 8'hF8, 8'h00},
    '{8'hA4, 1'b1, 7'd3, 8'hA6, 1'b0, 8'hF8, 8'h00},
    '{8'hA5, 1'b1, 7'd2, 8'h00, 1'b1, 8'hD0, 8'h90},
    '{8'hA4, 1'b1, 7'd2, 8'h00, 1'b0, 8'hF8, 8'h00},
    '{8'h22, 1'b0, 7'd2, 8'h22, 1'b0, 8'hF8, 8'h00},
    '{8'hFE, 1'b1, 7'd1, 8'hFE, 1'b1, 8'h60, 8'h80},
    '{8'h23, 1'b0, 7'd1, 8'h00, 1'b1, 8'hD0, 8'h98},
    '{8'hA5, 1'b1, 7'd2, 8'hA4, 1'b1, 8'h60, 8'h80}
  };

  vec_t       tv;
  logic       ackBit;
  logic [7:0] rdv;

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'(v * 37 + k * 11 + 5);
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic setCtl(input logic en, input logic ack);
    hostWrite(3'd0, {en, ack, 6'b000000});
  endtask

  task automatic sclHigh();
    sclDrv = 1'b1;
    for (int k = 0; k < 4000 && !sclLine; k++) @(negedge clk);
    waitCyc(Q);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitCyc(Q);
    sclHigh();
    sdaDrv = 1'b0; waitCyc(Q);
    sclDrv = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitCyc(Q);
    sclHigh();
    sdaDrv = 1'b1; waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitCyc(Q);
      sclHigh();
      sclDrv = 1'b0; waitCyc(Q);
    end
    sdaDrv = 1'b1; waitCyc(Q);
    sclHigh();
    ack = !sdaLine;
    sclDrv = 1'b0; waitCyc(Q);
  endtask

  task automatic readBuf(input int idx, output logic [7:0] d);
    hostWrite(3'd4, 8'(idx));
    hostRead(3'd5, d);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run-complete actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    hostRead(3'd3, rdv); chk(rdv, 8'hF8, "R1", "reset status");
    hostRead(3'd0, rdv); chk(rdv, 8'h00, "R1", "reset control");
    chk({7'd0, irqN},   8'h01, "R1", "reset irqN");
    chk({7'd0, sclLow}, 8'h00, "R1", "reset sclLow");
    chk({7'd0, sdaLow}, 8'h00, "R1", "reset sdaLow");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      tv = VECS[v];
      hostWrite(3'd1, tv.own);
      hostWrite(3'd2, {1'b0, tv.cnt});
      setCtl(1'b1, tv.ackEn);
      busStart();
      sendByte(tv.addrByte, ackBit);
      chk({7'd0, ackBit}, {7'd0, tv.expAck}, (tv.addrByte == 8'h00) ? "R3" : "R2", "address ack");
      hostRead(3'd3, rdv);
      chk(rdv, tv.expAddrStat, (tv.addrByte == 8'h00) ? "R3" : "R2", "address status");
      chk({7'd0, irqN}, {7'd0, !tv.expAck}, "R2", "irqN after address");
      if (tv.expAck) begin
        setCtl(1'b1, tv.ackEn);
        hostRead(3'd3, rdv); chk(rdv, 8'hF8, "R5", "status after clear");
        for (int k = 0; k < int'(tv.cnt); k++) begin
          sendByte(pat(v, k), ackBit);
          chk({7'd0, ackBit}, (k < int'(tv.cnt) - 1) ? 8'h01 : {7'd0, tv.ackEn}, "R8", "data ack");
        end
        hostRead(3'd3, rdv); chk(rdv, tv.expFinal, "R6", "burst status");
        chk({7'd0, irqN}, 8'h00, "R6", "irqN after burst");
        for (int k = 0; k < int'(tv.cnt); k++) begin
          readBuf(k, rdv); chk(rdv, pat(v, k), "R6", "buffer byte");
        end
        setCtl(1'b1, tv.ackEn);
        busStop();
        hostRead(3'd3, rdv);
        if (tv.ackEn) begin
          chk(rdv, 8'hA0, "R9", "stop in data phase");
          setCtl(1'b1, tv.ackEn);
        end else begin
          chk(rdv, 8'hF8, "R8", "stop after nack is silent");
          chk({7'd0, irqN}, 8'h01, "R8", "no flag after nack stop");
        end
      end else begin
        busStop();
        hostRead(3'd3, rdv); chk(rdv, 8'hF8, "R10", "stop while unaddressed");
        chk({7'd0, irqN}, 8'h01, "R10", "no irq while unaddressed");
      end
    end

    // R4 disabled interface
    hostWrite(3'd1, 8'hA4);
    hostWrite(3'd2, 8'd2);
    setCtl(1'b0, 1'b1);
    busStart();
    sendByte(8'hA4, ackBit);
    chk({7'd0, ackBit}, 8'h00, "R4", "no ack when disabled");
    chk({7'd0, irqN}, 8'h01, "R4", "no irq when disabled");
    busStop();

    // R5 stretch, write-1 ignored, R9 repeated start and mid-burst stop
    setCtl(1'b1, 1'b1);
    busStart();
    sendByte(8'hA4, ackBit);
    hostWrite(3'd0, 8'hC8);
    chk({7'd0, irqN}, 8'h00, "R5", "flag kept on write-1");
    hostRead(3'd3, rdv); chk(rdv, 8'h60, "R5", "status kept on write-1");
    sclDrv = 1'b1; waitCyc(20);
    chk({7'd0, sclLine}, 8'h00, "R5", "SCL held low while pending");
    setCtl(1'b1, 1'b1);
    waitCyc(3);
    chk({7'd0, sclLine}, 8'h01, "R5", "SCL released after clear");
    chk({7'd0, irqN}, 8'h01, "R5", "irqN high after clear");
    waitCyc(Q);
    sdaDrv = 1'b0; waitCyc(Q);
    hostRead(3'd3, rdv); chk(rdv, 8'hA0, "R9", "repeated start in data phase");
    sclDrv = 1'b0; waitCyc(Q);
    setCtl(1'b1, 1'b1);
    sendByte(8'hA4, ackBit);
    chk({7'd0, ackBit}, 8'h01, "R9", "re-address ack");
    hostRead(3'd3, rdv); chk(rdv, 8'h60, "R9", "re-address status");
    setCtl(1'b1, 1'b1);
    sendByte(8'h5A, ackBit);
    chk({7'd0, irqN}, 8'h01, "R6", "no irq before count");
    busStop();
    hostRead(3'd3, rdv); chk(rdv, 8'hA0, "R9", "stop mid-burst");
    readBuf(0, rdv); chk(rdv, 8'h5A, "R9", "partial byte kept");
    setCtl(1'b1, 1'b1);

    // R7 count 0 acts as 1
    hostWrite(3'd2, 8'd0);
    busStart();
    sendByte(8'hA4, ackBit);
    setCtl(1'b1, 1'b1);
    sendByte(8'h77, ackBit);
    hostRead(3'd3, rdv); chk(rdv, 8'h80, "R7", "count zero acts as one");
    setCtl(1'b1, 1'b1);
    busStop();
    setCtl(1'b1, 1'b1);

    // R7 count above 68 acts as 68
    hostWrite(3'd2, 8'd100);
    busStart();
    sendByte(8'hA4, ackBit);
    setCtl(1'b1, 1'b1);
    for (int k = 0; k < 67; k++) sendByte(pat(50, k), ackBit);
    chk({7'd0, irqN}, 8'h01, "R7", "no irq after 67 bytes");
    sendByte(pat(50, 67), ackBit);
    hostRead(3'd3, rdv); chk(rdv, 8'h80, "R7", "irq after 68 bytes");
    readBuf(67, rdv); chk(rdv, pat(50, 67), "R7", "last buffer entry");
    readBuf(0, rdv);  chk(rdv, pat(50, 0), "R7", "first buffer entry");
    setCtl(1'b1, 1'b1);
    busStop();
    setCtl(1'b1, 1'b1);

    // R6 second sequence restarts at index 0
    hostWrite(3'd2, 8'd2);
    busStart();
    sendByte(8'hA4, ackBit);
    setCtl(1'b1, 1'b1);
    sendByte(8'h11, ackBit);
    sendByte(8'h22, ackBit);
    setCtl(1'b1, 1'b1);
    sendByte(8'h33, ackBit);
    sendByte(8'h44, ackBit);
    hostRead(3'd3, rdv); chk(rdv, 8'h80, "R6", "second burst status");
    readBuf(0, rdv); chk(rdv, 8'h33, "R6", "second burst index 0");
    readBuf(1, rdv); chk(rdv, 8'h44, "R6", "second burst index 1");
    setCtl(1'b1, 1'b1);
    busStop();
    setCtl(1'b1, 1'b1);

    // R8 nack on final byte, then bytes ignored
    busStart();
    sendByte(8'hA4, ackBit);
    setCtl(1'b1, 1'b0);
    sendByte(8'h66, ackBit);
    chk({7'd0, ackBit}, 8'h01, "R8", "non-final byte acked");
    sendByte(8'h67, ackBit);
    chk({7'd0, ackBit}, 8'h00, "R8", "final byte nacked");
    hostRead(3'd3, rdv); chk(rdv, 8'h88, "R8", "nack status");
    setCtl(1'b1, 1'b0);
    sendByte(8'h68, ackBit);
    chk({7'd0, ackBit}, 8'h00, "R8", "byte after nack ignored");
    chk({7'd0, irqN}, 8'h01, "R8", "no irq after nack");
    readBuf(0, rdv); chk(rdv, 8'h66, "R8", "buffer untouched after nack");
    busStop();
    hostRead(3'd3, rdv); chk(rdv, 8'hF8, "R10", "stop after skip is silent");

    summary();
    $finish;
  end

endmodule